// File: doc/BRIEF.md
# Serial Audio Re-timing Buffer

This block takes a stereo serial audio stream (bit clock, data and word clock) that arrives with the jitter of a recovered clock, and sends it out again timed by a clean local oscillator. A capture stage oversamples the three incoming lines on the recovered master clock. It rebuilds each left/right pair of 24-bit words and writes the pair into a small dual-clock buffer. A playout stage runs on the clean clock. It pulls pairs from the buffer and generates a fresh bit clock, data line and word clock for a downstream digital filter.

Both clocks have the same nominal rate but are not locked together. Playout therefore waits until the buffer reaches a fill threshold and then runs until the buffer runs dry. While it is idle it sends silence, and its clocks keep running. Sticky flags report lost input (buffer full) and starvation (buffer empty). Each flag has a synchronous clear in its own clock domain.

Top module: `audio_reclock_fifo`

## Requirements
- R1: Capture samples the serial lines on rising edges of the incoming bit clock. Word clock low means left and high means right. A change of word clock marks the MSB of a new 24-bit channel word, and bits arrive MSB first. A pair is stored once the 24th right bit arrives after a complete left word.
- R2: Stored pairs come out in arrival order, one pair per 48-bit output frame. The output word clock is low for the 24 left bits and high for the 24 right bits, MSB first. Each bit lasts 2*HALF read-clock cycles, and data changes while the output bit clock is low.
- R3: A pair that completes while the buffer is full is dropped, and `overflow` sets and stays set.
- R4: At a frame boundary, if playout is active and the buffer is empty, playout stops, `underflow` sets and stays set, and the next frame carries zeros instead of stale data.
- R5: Playout starts only at a frame boundary where the read-side fill is at least AF_LEVEL (default DEPTH/2).
- R6: While playout is inactive, every output frame is all zeros and the output bit and word clocks keep running.
- R7: `empty`, `almostFull` and `rdEn` give the read-domain view: buffer empty, fill at least AF_LEVEL, and playout active.
- R8: `wrClr` clears `overflow`, and `rdClr` clears `underflow`. A clear takes priority over a new event in the same cycle.
- R9: After reset, `overflow`, `underflow`, `rdEn` and `almostFull` are 0, `empty` is 1 and the output data line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered master clock (capture domain) |
| wrRst_n | input | 1 | Active-low reset, capture domain |
| wrClr | input | 1 | Clears the overflow flag |
| sBclk | input | 1 | Incoming serial bit clock |
| sData | input | 1 | Incoming serial data |
| sLrck | input | 1 | Incoming word clock (0 = left) |
| overflow | output | 1 | Sticky: a pair was dropped on a full buffer |
| rdClk | input | 1 | Clean oscillator clock (playout domain) |
| rdRst_n | input | 1 | Active-low reset, playout domain |
| rdClr | input | 1 | Clears the underflow flag |
| oBclk | output | 1 | Regenerated bit clock |
| oData | output | 1 | Regenerated serial data |
| oLrck | output | 1 | Regenerated word clock (0 = left) |
| almostFull | output | 1 | Read-side fill at least AF_LEVEL |
| empty | output | 1 | Read-side view of an empty buffer |
| rdEn | output | 1 | Playout active |
| underflow | output | 1 | Sticky: playout ran dry |

## Verification
A pair reaches the output at the earliest one frame boundary after its write pointer has crossed the two-flop synchronizer. It then takes a full 48-bit frame to shift out. The scoreboard therefore matches whole frames, decoded at the rising edges of the output bit clock and aligned by the word-clock fall, rather than counting clock cycles. The flags change only at frame boundaries (underflow) or on a completed write (overflow). They are sampled several frames after the stimulus that causes them, so synchronizer delay and frame phase cannot move a result past the sampling point. All outputs are read on the falling read-clock edge, away from the edge that updates them.

// File: rtl/arf_pkg.sv
package arf_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;  // capture domain: write wordReg into the buffer
    logic load;  // playout domain: frame boundary, reload shifter
    logic fill;  // playout domain: load from buffer (else zeros) and pop
  } arfStb_t;
endpackage

// File: rtl/arf_datapath.sv
module arf_datapath
  import arf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int CH_BITS = 24,
  parameter int HALF    = 2,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          wrRst_n,
  input  logic          rdClk,
  input  logic          rdRst_n,
  input  logic          sBclk,
  input  logic          sData,
  input  logic          sLrck,
  input  arfStb_t       stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  output logic          wordDone,
  output logic          frameEnd,
  output logic          oBclk,
  output logic          oData,
  output logic          oLrck
);
  localparam int WORD = 2 * CH_BITS;
  localparam int CW   = $clog2(CH_BITS + 1);
  localparam int BW   = $clog2(WORD);
  localparam int PHW  = $clog2(2 * HALF);

  // ---------------- capture side ----------------
  logic [2:0]         syncA, syncB;
  logic               bPrev, lastLr, haveLeft;
  logic [CW-1:0]      cnt, nextCnt;
  logic [CH_BITS-1:0] shIn, shNext, leftReg;
  logic [WORD-1:0]    wordReg;
  logic               rise, bitIn, lrIn, change, complete;

  assign rise    = syncB[2] & ~bPrev;
  assign bitIn   = syncB[1];
  assign lrIn    = syncB[0];
  assign change  = lrIn != lastLr;
  assign shNext  = {shIn[CH_BITS-2:0], bitIn};
  assign nextCnt = change ? CW'(1) : ((cnt < CW'(CH_BITS)) ? cnt + 1'b1 : cnt);
  assign complete = rise && (change || cnt < CW'(CH_BITS)) && nextCnt == CW'(CH_BITS);

  always_ff @(posedge wrClk or negedge wrRst_n) begin
    if (!wrRst_n) begin
      syncA <= '0; syncB <= '0; bPrev <= 1'b0;
      lastLr <= 1'b1; cnt <= '0; shIn <= '0;
      leftReg <= '0; haveLeft <= 1'b0; wordReg <= '0; wordDone <= 1'b0;
    end else begin
      syncA <= {sBclk, sData, sLrck};
      syncB <= syncA;
      bPrev <= syncB[2];
      wordDone <= 1'b0;
      if (rise) begin
        shIn   <= shNext;
        cnt    <= nextCnt;
        lastLr <= lrIn;
      end
      if (complete) begin
        if (!lrIn) begin
          leftReg  <= shNext;
          haveLeft <= 1'b1;
        end else if (haveLeft) begin
          wordReg  <= {leftReg, shNext};
          wordDone <= 1'b1;
          haveLeft <= 1'b0;
        end
      end
    end
  end

  // ---------------- buffer storage ----------------
  logic [WORD-1:0] mem [DEPTH];
  always_ff @(posedge wrClk) begin
    if (stb.push) mem[wrAddr] <= wordReg;
  end

  // ---------------- playout side ----------------
  logic [PHW-1:0]  phase;
  logic [BW-1:0]   bitIdx;
  logic [WORD-1:0] shOut;
  logic            lastPh;

  assign lastPh   = phase == PHW'(2 * HALF - 1);
  assign frameEnd = lastPh && bitIdx == BW'(WORD - 1);

  always_ff @(posedge rdClk or negedge rdRst_n) begin
    if (!rdRst_n) begin
      phase <= '0; bitIdx <= '0; shOut <= '0;
    end else begin
      phase <= lastPh ? '0 : phase + 1'b1;
      if (lastPh) bitIdx <= frameEnd ? '0 : bitIdx + 1'b1;
      if (stb.load)   shOut <= stb.fill ? mem[rdAddr] : '0;
      else if (lastPh) shOut <= {shOut[WORD-2:0], 1'b0};
    end
  end

  assign oBclk = phase >= PHW'(HALF);
  assign oData = shOut[WORD-1];
  assign oLrck = bitIdx >= BW'(CH_BITS);
endmodule

// File: rtl/arf_ctrl.sv
module arf_ctrl
  import arf_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = DEPTH / 2,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          wrRst_n,
  input  logic          wrClr,
  input  logic          rdClk,
  input  logic          rdRst_n,
  input  logic          rdClr,
  input  logic          wordDone,
  input  logic          frameEnd,
  output arfStb_t       stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          almostFull,
  output logic          empty,
  output logic          rdEn,
  output logic          overflow,
  output logic          underflow
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- capture domain ----------------
  logic [PW-1:0] wrBin, wrGray, rdG1, rdG2, wrBinNext;
  logic          full, push;

  assign full      = (wrBin - g2b(rdG2)) == PW'(DEPTH);
  assign push      = wordDone & ~full;
  assign wrBinNext = wrBin + PW'(push);

  always_ff @(posedge wrClk or negedge wrRst_n) begin
    if (!wrRst_n) begin
      wrBin <= '0; wrGray <= '0; rdG1 <= '0; rdG2 <= '0; overflow <= 1'b0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= wrBinNext ^ (wrBinNext >> 1);
      rdG1   <= rdGray;
      rdG2   <= rdG1;
      if (wrClr)                overflow <= 1'b0;
      else if (wordDone && full) overflow <= 1'b1;
    end
  end

  // ---------------- playout domain ----------------
  logic [PW-1:0] rdBin, rdGray, wrG1, wrG2, fillLvl, rdBinNext;
  logic          playing, takeNow;

  assign fillLvl    = g2b(wrG2) - rdBin;
  assign empty      = fillLvl == '0;
  assign almostFull = fillLvl >= PW'(AF_LEVEL);
  assign takeNow    = frameEnd && (playing ? !empty : almostFull);
  assign rdBinNext  = rdBin + PW'(takeNow);

  always_ff @(posedge rdClk or negedge rdRst_n) begin
    if (!rdRst_n) begin
      rdBin <= '0; rdGray <= '0; wrG1 <= '0; wrG2 <= '0;
      playing <= 1'b0; underflow <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdBinNext ^ (rdBinNext >> 1);
      wrG1   <= wrGray;
      wrG2   <= wrG1;
      if (frameEnd) playing <= takeNow;
      if (rdClr)                            underflow <= 1'b0;
      else if (frameEnd && playing && empty) underflow <= 1'b1;
    end
  end

  always_comb begin
    stb.push = push;
    stb.load = frameEnd;
    stb.fill = takeNow;
  end

  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];
  assign rdEn   = playing;
endmodule

// File: rtl/audio_reclock_fifo.sv
module audio_reclock_fifo
  import arf_pkg::*;
#(
  parameter int DEPTH    = 8,   // power of two
  parameter int CH_BITS  = 24,
  parameter int HALF     = 2,   // read clocks per output bit-clock half
  parameter int AF_LEVEL = DEPTH / 2
) (
  input  logic wrClk,
  input  logic wrRst_n,
  input  logic wrClr,
  input  logic sBclk,
  input  logic sData,
  input  logic sLrck,
  output logic overflow,
  input  logic rdClk,
  input  logic rdRst_n,
  input  logic rdClr,
  output logic oBclk,
  output logic oData,
  output logic oLrck,
  output logic almostFull,
  output logic empty,
  output logic rdEn,
  output logic underflow
);
  localparam int AW = $clog2(DEPTH);

  arfStb_t       stb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          wordDone, frameEnd;

  arf_ctrl #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_ctrl (
    .wrClk(wrClk), .wrRst_n(wrRst_n), .wrClr(wrClr),
    .rdClk(rdClk), .rdRst_n(rdRst_n), .rdClr(rdClr),
    .wordDone(wordDone), .frameEnd(frameEnd), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .almostFull(almostFull), .empty(empty), .rdEn(rdEn),
    .overflow(overflow), .underflow(underflow)
  );

  arf_datapath #(.DEPTH(DEPTH), .CH_BITS(CH_BITS), .HALF(HALF)) u_dp (
    .wrClk(wrClk), .wrRst_n(wrRst_n), .rdClk(rdClk), .rdRst_n(rdRst_n),
    .sBclk(sBclk), .sData(sData), .sLrck(sLrck),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wordDone(wordDone), .frameEnd(frameEnd),
    .oBclk(oBclk), .oData(oData), .oLrck(oLrck)
  );
endmodule

// File: rtl/arf_checker.sv
module arf_checker
  import arf_pkg::*;
(
  input logic    wrClk,
  input logic    wrRst_n,
  input logic    rdClk,
  input logic    rdRst_n,
  input arfStb_t stb,
  input logic    wordDone,
  input logic    frameEnd,
  input logic    oData,
  input logic    oLrck,
  input logic    overflow,
  input logic    underflow,
  input logic    empty,
  input logic    rdEn
);
  // R3: overflow only rises on a completed write attempt
  p_ovf_on_write_r3: assert property (@(posedge wrClk) disable iff (!wrRst_n)
    $rose(overflow) |-> $past(wordDone));

  // R4: an empty buffer at a frame boundary ends playout
  p_stop_on_empty_r4: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    (rdEn && stb.load && empty) |=> !rdEn);

  // R4: underflow is never raised while still playing
  p_ufl_idle_r4: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    $rose(underflow) |-> !rdEn);

  // R4: never pop from an empty buffer
  p_no_empty_pop_r4: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    stb.fill |-> !empty);

  // R6: silence while idle
  p_idle_zero_r6: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    !rdEn |-> !oData);

  // R2: every frame opens with the left half
  p_frame_left_r2: assert property (@(posedge rdClk) disable iff (!rdRst_n)
    frameEnd |=> !oLrck);
endmodule

bind audio_reclock_fifo arf_checker u_chk (
  .wrClk(wrClk), .wrRst_n(wrRst_n), .rdClk(rdClk), .rdRst_n(rdRst_n),
  .stb(stb), .wordDone(wordDone), .frameEnd(frameEnd),
  .oData(oData), .oLrck(oLrck), .overflow(overflow), .underflow(underflow),
  .empty(empty), .rdEn(rdEn)
);

// File: tb/sim_audio_reclock_fifo.sv
`timescale 1ns/1ps
module sim_audio_reclock_fifo;
  localparam int DEPTH = 8, AF = DEPTH / 2, HALF = 2;

  logic wrClk = 0, rdClk = 0, wrRst_n = 0, rdRst_n = 0;
  logic wrClr = 0, rdClr = 0, sBclk = 0, sData = 0, sLrck = 0;
  logic overflow, oBclk, oData, oLrck, almostFull, empty, rdEn, underflow;

  always #1 wrClk = ~wrClk;   // capture clock, 2 ns
  always #2 rdClk = ~rdClk;   // 250 MHz clean clock

  audio_reclock_fifo #(.DEPTH(DEPTH), .HALF(HALF)) u0 (.*);

  int tests = 0, fails = 0;
  logic [47:0] expQ[$];
  int doneCount = 0, nonzero = 0, zeroFrames = 0, perErr = 0, seenNz = 0;
  bit strict = 1, monOn = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: serial stream, half = capture clocks per bit-clock half
  task automatic sendPair(input logic [23:0] l, r, input int half);
    logic [47:0] w;
    w = {l, r};
    expQ.push_back(w);
    for (int b = 0; b < 48; b++) begin
      @(negedge wrClk);
      sLrck = (b >= 24); sData = w[47-b]; sBclk = 0;
      repeat (half - 1) @(negedge wrClk);
      @(negedge wrClk); sBclk = 1;
      repeat (half - 1) @(negedge wrClk);
    end
    doneCount++;
  endtask

  task automatic frameDone(input logic [47:0] f);
    if (f == '0) begin zeroFrames++; return; end
    nonzero++;
    if (!seenNz) begin
      seenNz = 1;
      check(doneCount >= AF, "R5 start threshold", doneCount, AF);
    end
    if (strict) begin
      if (expQ.size() == 0) check(0, "R2 unexpected frame", f, 0);
      else begin
        logic [47:0] e;
        e = expQ.pop_front();
        check(f == e, "R1/R2 frame data", f, e);
      end
    end else begin
      bit hit;
      hit = 0;
      while (expQ.size() > 0 && !hit) hit = (expQ.pop_front() == f);
      check(hit, "R3 frame not among sent pairs", f, 0);
    end
  endtask

  // monitor: decode output frames on the falling read-clock edge
  logic prevB = 0, prevLr = 1, seenRise = 0;
  int cnt = 0, sinceRise = 0;
  logic [47:0] sh = '0;
  always @(negedge rdClk) begin
    if (monOn) begin
      if (oBclk && !prevB) begin
        if (seenRise && sinceRise != 2 * HALF) perErr++;
        sinceRise = 0; seenRise = 1;
        if (!oLrck && prevLr) begin cnt = 1; sh = {47'b0, oData}; end
        else begin sh = {sh[46:0], oData}; cnt++; end
        prevLr = oLrck;
        if (cnt == 48) frameDone(sh);
      end
      sinceRise++;
      prevB = oBclk;
    end
  end

  initial begin
    fork
      begin
        int nz0, z0, sent;
        repeat (10) @(negedge rdClk);
        wrRst_n = 1; rdRst_n = 1;
        @(negedge rdClk);
        // R9 reset state
        check(overflow == 0, "R9 overflow", overflow, 0);
        check(underflow == 0, "R9 underflow", underflow, 0);
        check(rdEn == 0, "R9 rdEn", rdEn, 0);
        check(empty == 1, "R9 empty", empty, 1);
        check(almostFull == 0 && oData == 0, "R9 almostFull/oData", {almostFull, oData}, 0);
        monOn = 1;
        // R6 idle: clocks run, frames are zero
        repeat (500) @(negedge rdClk);
        check(zeroFrames >= 2, "R6 idle frames", zeroFrames, 2);
        check(nonzero == 0, "R6 idle silence", nonzero, 0);
        // R1/R2/R5 normal stream at matched rate
        for (int i = 0; i < 20; i++) begin
          sendPair({4'hA, 20'(i + 1)}, {4'h5, 20'(3 * i + 7)}, 4);
          if (i == 12) check(rdEn == 1, "R7 rdEn while streaming", rdEn, 1);
        end
        // R4 stream stops: buffer drains and starves
        repeat (2500) @(negedge rdClk);
        check(underflow == 1, "R4 underflow set", underflow, 1);
        check(rdEn == 0, "R7 rdEn after starve", rdEn, 0);
        check(empty == 1, "R7 empty after starve", empty, 1);
        check(expQ.size() == 0, "R2 all pairs played", expQ.size(), 0);
        nz0 = nonzero; z0 = zeroFrames;
        repeat (600) @(negedge rdClk);
        check(nonzero == nz0 && zeroFrames > z0, "R6 zeros after underflow", nonzero - nz0, 0);
        // R8 read-side clear
        @(negedge rdClk); rdClr = 1; @(negedge rdClk); rdClr = 0;
        @(negedge rdClk);
        check(underflow == 0, "R8 rdClr", underflow, 0);
        // R3 write at double rate
        strict = 0; nz0 = nonzero;
        for (int i = 0; i < 40; i++)
          sendPair({4'hC, 20'(i + 1)}, {4'h3, 20'(5 * i + 2)}, 2);
        check(overflow == 1, "R3 overflow set", overflow, 1);
        repeat (3000) @(negedge rdClk);
        sent = 40;
        check(nonzero - nz0 < sent, "R3 pairs dropped", nonzero - nz0, sent);
        check(overflow == 1, "R3 overflow sticky", overflow, 1);
        expQ.delete();
        // R8 write-side clear
        @(negedge wrClk); wrClr = 1; @(negedge wrClk); wrClr = 0;
        @(negedge wrClk);
        check(overflow == 0, "R8 wrClr", overflow, 0);
        check(perErr == 0, "R2 bit period", perErr, 0);
      end
      begin
        #400us;
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule